// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Evaluator

This block sits inside an interrupt distributor and answers one question for every CPU interface: is there at least one interrupt that this CPU could take right now? Interrupts are split into a banked range (ids 0 to 31, with a private copy of line state, enable and in-progress bit per CPU) and a shared range (ids 32 and up, one copy each, steered to a single CPU by a target index). Each id carries a trigger type: level or edge.

Level interrupts need protection from being taken twice. When a level interrupt is handed to a CPU (delivery strobe with id and CPU), an in-progress bit is set. While that bit is set the line is masked. The end-of-interrupt strobe clears the bit, and the line is then looked at again. Edge interrupts never use the in-progress bit. The result is one registered pending flag per CPU. Choosing which interrupt to deliver is left to the logic around this block.

Top module: `pev_top`

## Requirements
- R1: In the banked range, CPU c is pending when, for some id i < 32, bit c*32+i is 1 in both `line_bank` and `en_bank` and the interrupt is not masked by its in-progress bit.
- R2: A shared id 32+j makes a CPU pending only when `line_shr[j]`, `en_shr[j]` are both 1 and that CPU's index equals the target field `tgt_shr[j*CW +: CW]`.
- R3: A shared interrupt is pending on at most one CPU, and a change of its target field moves the pending flag to the new CPU.
- R4: A delivery strobe for a level id (`trig_edge[id]` = 0) sets that id's in-progress bit (banked: in the bank of `dlv_cpu`). While the bit is set the line does not make the CPU pending.
- R5: An end-of-interrupt strobe for an id clears its in-progress bit (banked: in the bank of `eoi_cpu`). The line counts again from then on.
- R6: Dropping a level line removes its pending contribution but leaves its in-progress bit set. Raising it again before end-of-interrupt gives no pending.
- R7: With `dist_en` = 0, `pend_q` is exactly 1 on CPU 0 and 0 on all other CPUs.
- R8: `pend_q` is a register. It reflects the inputs and in-progress state as of the previous rising clock edge and does not change between edges.
- R9: A delivery strobe for an edge id (`trig_edge[id]` = 1) leaves the in-progress state unchanged. The id stays pending while its line and enable stay high.
- R10: While `rst_n` is low, `pend_q` is 0 and all in-progress bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en | input | 1 | Distributor enable |
| line_bank | input | NCPU*32 | Banked line states, bit c*32+i = id i in CPU c's bank |
| en_bank | input | NCPU*32 | Banked enables, same layout |
| line_shr | input | NSHR | Shared line states, bit j = id 32+j |
| en_shr | input | NSHR | Shared enables |
| tgt_shr | input | NSHR*CW | Target CPU index per shared id |
| trig_edge | input | 32+NSHR | Trigger type per id, 1 = edge, 0 = level |
| dlv_vld | input | 1 | Delivery strobe |
| dlv_id | input | IDW | Delivered interrupt id |
| dlv_cpu | input | CW | CPU the interrupt was delivered to |
| eoi_vld | input | 1 | End-of-interrupt strobe |
| eoi_id | input | IDW | Completed interrupt id |
| eoi_cpu | input | CW | CPU completing the interrupt |
| pend_q | output | NCPU | Registered per-CPU pending summary |

## Verification
The bench checks several things. A line and an enable that sit in different CPU banks must not make either CPU pending. A design that ORs the banks together would flag one of them. A shared interrupt is retargeted and must move cleanly from one CPU to the other. A design that decodes the target wrongly would leave it on both CPUs or on the old one. The bench delivers a level interrupt, drops its line and raises it again before end-of-interrupt. A design that clears the in-progress bit on line drop would pend again too early. The bench delivers an edge interrupt and expects it to keep pending. It also checks the disabled state, where only CPU 0 may show pending. A design that reports the raw pending vector there would show other CPUs.

// File: rtl/pev_pkg.sv
package pev_pkg;
    // Number of ids in each CPU's private bank.
    localparam int BANK_IRQS = 32;
endpackage

// File: rtl/pev_active.sv
module pev_active
    import pev_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSHR = 32,
    localparam int NIRQ = BANK_IRQS + NSHR,
    localparam int IDW  = $clog2(NIRQ),
    localparam int CW   = $clog2(NCPU)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NIRQ-1:0]           trig_edge,
    input  logic                      dlv_vld,
    input  logic [IDW-1:0]            dlv_id,
    input  logic [CW-1:0]             dlv_cpu,
    input  logic                      eoi_vld,
    input  logic [IDW-1:0]            eoi_id,
    input  logic [CW-1:0]             eoi_cpu,
    output logic [NCPU*BANK_IRQS-1:0] act_bank_d,
    output logic [NSHR-1:0]           act_shr_d,
    output logic [NCPU*BANK_IRQS-1:0] act_bank_q,
    output logic [NSHR-1:0]           act_shr_q
);
    typedef struct packed {
        logic [NCPU*BANK_IRQS-1:0] bank;
        logic [NSHR-1:0]           shr;
    } act_t;

    act_t st_d, st_q;

    always_comb begin
        int eid, ecpu, did, dcpu;
        st_d = st_q;
        eid  = int'(eoi_id);
        ecpu = int'(eoi_cpu);
        did  = int'(dlv_id);
        dcpu = int'(dlv_cpu);
        // Completion first, so a delivery in the same cycle wins.
        if (eoi_vld && eid < NIRQ) begin
            if (eid < BANK_IRQS) st_d.bank[ecpu*BANK_IRQS + eid] = 1'b0;
            else                 st_d.shr[eid - BANK_IRQS]       = 1'b0;
        end
        if (dlv_vld && did < NIRQ && !trig_edge[did]) begin
            if (did < BANK_IRQS) st_d.bank[dcpu*BANK_IRQS + did] = 1'b1;
            else                 st_d.shr[did - BANK_IRQS]       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_bank_d = st_d.bank;
    assign act_shr_d  = st_d.shr;
    assign act_bank_q = st_q.bank;
    assign act_shr_q  = st_q.shr;
endmodule

// File: rtl/pev_eval.sv
module pev_eval
    import pev_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSHR = 32,
    localparam int NIRQ = BANK_IRQS + NSHR,
    localparam int CW   = $clog2(NCPU)
) (
    input  logic [NCPU*BANK_IRQS-1:0] line_bank,
    input  logic [NCPU*BANK_IRQS-1:0] en_bank,
    input  logic [NSHR-1:0]           line_shr,
    input  logic [NSHR-1:0]           en_shr,
    input  logic [NSHR*CW-1:0]        tgt_shr,
    input  logic [NIRQ-1:0]           trig_edge,
    input  logic [NCPU*BANK_IRQS-1:0] act_bank,
    input  logic [NSHR-1:0]           act_shr,
    output logic [NCPU-1:0]           raw_pend
);
    logic [BANK_IRQS-1:0] lvl_bank;
    logic [NSHR-1:0]      shr_ok;

    assign lvl_bank = ~trig_edge[BANK_IRQS-1:0];
    assign shr_ok   = line_shr & en_shr & ~(act_shr & ~trig_edge[NIRQ-1:BANK_IRQS]);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [BANK_IRQS-1:0] bank_ok;
        logic [NSHR-1:0]      mine;
        assign bank_ok = line_bank[c*BANK_IRQS +: BANK_IRQS]
                       & en_bank[c*BANK_IRQS +: BANK_IRQS]
                       & ~(act_bank[c*BANK_IRQS +: BANK_IRQS] & lvl_bank);
        for (genvar j = 0; j < NSHR; j++) begin : g_tgt
            assign mine[j] = (tgt_shr[j*CW +: CW] == CW'(c));
        end
        assign raw_pend[c] = (|bank_ok) | (|(shr_ok & mine));
    end
endmodule

// File: rtl/pev_top.sv
module pev_top
    import pev_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSHR = 32,
    localparam int NIRQ = BANK_IRQS + NSHR,
    localparam int IDW  = $clog2(NIRQ),
    localparam int CW   = $clog2(NCPU)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dist_en,
    input  logic [NCPU*BANK_IRQS-1:0] line_bank,
    input  logic [NCPU*BANK_IRQS-1:0] en_bank,
    input  logic [NSHR-1:0]           line_shr,
    input  logic [NSHR-1:0]           en_shr,
    input  logic [NSHR*CW-1:0]        tgt_shr,
    input  logic [NIRQ-1:0]           trig_edge,
    input  logic                      dlv_vld,
    input  logic [IDW-1:0]            dlv_id,
    input  logic [CW-1:0]             dlv_cpu,
    input  logic                      eoi_vld,
    input  logic [IDW-1:0]            eoi_id,
    input  logic [CW-1:0]             eoi_cpu,
    output logic [NCPU-1:0]           pend_q
);
    typedef struct packed {
        logic [NCPU-1:0] pend;
    } sum_t;

    logic [NCPU*BANK_IRQS-1:0] act_bank_d, act_bank;
    logic [NSHR-1:0]           act_shr_d, act_shr;
    logic [NCPU-1:0]           raw_pend;
    sum_t                      sum_d, sum_q;

    pev_active #(.NCPU(NCPU), .NSHR(NSHR)) u_act (
        .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge),
        .dlv_vld(dlv_vld), .dlv_id(dlv_id), .dlv_cpu(dlv_cpu),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .eoi_cpu(eoi_cpu),
        .act_bank_d(act_bank_d), .act_shr_d(act_shr_d),
        .act_bank_q(act_bank), .act_shr_q(act_shr)
    );

    // Evaluate against the in-progress state that becomes current at the
    // same edge, so summary and in-progress bits never disagree.
    pev_eval #(.NCPU(NCPU), .NSHR(NSHR)) u_eval (
        .line_bank(line_bank), .en_bank(en_bank),
        .line_shr(line_shr), .en_shr(en_shr), .tgt_shr(tgt_shr),
        .trig_edge(trig_edge), .act_bank(act_bank_d), .act_shr(act_shr_d),
        .raw_pend(raw_pend)
    );

    always_comb begin
        sum_d = sum_q;
        if (dist_en) sum_d.pend = raw_pend;
        else         sum_d.pend = NCPU'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign pend_q = sum_q.pend;
endmodule

// File: rtl/pev_checker.sv
module pev_checker
    import pev_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSHR = 32,
    localparam int NIRQ = BANK_IRQS + NSHR,
    localparam int IDW  = $clog2(NIRQ),
    localparam int CW   = $clog2(NCPU)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      dist_en,
    input logic [NCPU*BANK_IRQS-1:0] en_bank,
    input logic [NSHR-1:0]           en_shr,
    input logic [NIRQ-1:0]           trig_edge,
    input logic                      dlv_vld,
    input logic [IDW-1:0]            dlv_id,
    input logic [CW-1:0]             dlv_cpu,
    input logic                      eoi_vld,
    input logic [IDW-1:0]            eoi_id,
    input logic [CW-1:0]             eoi_cpu,
    input logic [NCPU*BANK_IRQS-1:0] act_bank,
    input logic [NSHR-1:0]           act_shr,
    input logic [NCPU-1:0]           pend_q
);
    function automatic logic act_at(input logic [IDW-1:0] id, input logic [CW-1:0] cpu);
        if (int'(id) < BANK_IRQS) return act_bank[int'(cpu)*BANK_IRQS + int'(id)];
        else                      return act_shr[int'(id) - BANK_IRQS];
    endfunction

    logic same_tgt;
    assign same_tgt = dlv_vld && (dlv_id == eoi_id) &&
                      (int'(dlv_id) >= BANK_IRQS || dlv_cpu == eoi_cpu);

    AST_OFF_ONLY_CPU0: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |=> pend_q == NCPU'(1)); // R7

    AST_NO_EN_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_en && en_bank == '0 && en_shr == '0) |=> pend_q == '0); // R1

    AST_LEVEL_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_vld && !trig_edge[dlv_id]) |=> act_at($past(dlv_id), $past(dlv_cpu))); // R4

    AST_EOI_CLEARS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld && !same_tgt) |=> !act_at($past(eoi_id), $past(eoi_cpu))); // R5

    AST_EDGE_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_vld && trig_edge[dlv_id] && !eoi_vld)
        |=> act_at($past(dlv_id), $past(dlv_cpu)) == $past(act_at(dlv_id, dlv_cpu))); // R9
endmodule

bind pev_top pev_checker #(.NCPU(NCPU), .NSHR(NSHR)) u_chk (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .en_bank(en_bank), .en_shr(en_shr),
    .trig_edge(trig_edge), .dlv_vld(dlv_vld), .dlv_id(dlv_id), .dlv_cpu(dlv_cpu),
    .eoi_vld(eoi_vld), .eoi_id(eoi_id), .eoi_cpu(eoi_cpu),
    .act_bank(act_bank), .act_shr(act_shr), .pend_q(pend_q)
);

// File: tb/sim_pev_top.sv
`timescale 1ns/1ps
module sim_pev_top;
    localparam int NCPU = 4;
    localparam int NSHR = 32;
    localparam int NIRQ = 32 + NSHR;
    localparam int IDW  = $clog2(NIRQ);
    localparam int CW   = $clog2(NCPU);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dist_en = 1'b0;
    logic [NCPU*32-1:0] line_bank = '0, en_bank = '0;
    logic [NSHR-1:0] line_shr = '0, en_shr = '0;
    logic [NSHR*CW-1:0] tgt_shr = '0;
    logic [NIRQ-1:0] trig_edge = '0;
    logic dlv_vld = 1'b0, eoi_vld = 1'b0;
    logic [IDW-1:0] dlv_id = '0, eoi_id = '0;
    logic [CW-1:0] dlv_cpu = '0, eoi_cpu = '0;
    logic [NCPU-1:0] pend_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Behavioural reference state.
    bit mab[NCPU][32];
    bit mas[NSHR];
    logic [NCPU-1:0] exp_pend = '0;

    always #2.5 clk = ~clk;

    pev_top #(.NCPU(NCPU), .NSHR(NSHR)) u0 (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en),
        .line_bank(line_bank), .en_bank(en_bank), .line_shr(line_shr), .en_shr(en_shr),
        .tgt_shr(tgt_shr), .trig_edge(trig_edge),
        .dlv_vld(dlv_vld), .dlv_id(dlv_id), .dlv_cpu(dlv_cpu),
        .eoi_vld(eoi_vld), .eoi_id(eoi_id), .eoi_cpu(eoi_cpu),
        .pend_q(pend_q)
    );

    task automatic check(input string tag, input logic [NCPU-1:0] act, input logic [NCPU-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pend_q=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one clock: update the model from the inputs, then compare.
    task automatic step(input string tag);
        if (!rst_n) begin
            foreach (mab[c, i]) mab[c][i] = 0;
            foreach (mas[j]) mas[j] = 0;
            exp_pend = '0;
        end else begin
            if (eoi_vld) begin
                if (eoi_id < 32) mab[eoi_cpu][eoi_id] = 0;
                else             mas[eoi_id - 32] = 0;
            end
            if (dlv_vld && !trig_edge[dlv_id]) begin
                if (dlv_id < 32) mab[dlv_cpu][dlv_id] = 1;
                else             mas[dlv_id - 32] = 1;
            end
            exp_pend = '0;
            if (!dist_en) exp_pend = 1;
            else begin
                for (int c = 0; c < NCPU; c++)
                    for (int i = 0; i < 32; i++)
                        if (line_bank[c*32+i] && en_bank[c*32+i] && !(!trig_edge[i] && mab[c][i]))
                            exp_pend[c] = 1'b1;
                for (int j = 0; j < NSHR; j++)
                    if (line_shr[j] && en_shr[j] && !(!trig_edge[32+j] && mas[j]))
                        exp_pend[tgt_shr[j*CW +: CW]] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        dlv_vld = 1'b0;
        eoi_vld = 1'b0;
        check(tag, pend_q, exp_pend);
    endtask

    task automatic deliver(input int id, input int cpu);
        dlv_vld = 1'b1; dlv_id = IDW'(id); dlv_cpu = CW'(cpu);
    endtask

    task automatic finish_eoi(input int id, input int cpu);
        eoi_vld = 1'b1; eoi_id = IDW'(id); eoi_cpu = CW'(cpu);
    endtask

    initial begin
        #1;
        // R10: reset state
        step("R10"); step("R10");
        line_bank = '1; en_bank = '1;
        step("R10");
        rst_n = 1'b1;
        // R7: disabled distributor reports CPU 0 only
        step("R7"); step("R7");
        line_bank = '0; en_bank = '0;
        step("R7");
        dist_en = 1'b1;
        step("R1 idle");
        // R1: banked id 5 on CPU 2
        line_bank[2*32+5] = 1'b1; en_bank[2*32+5] = 1'b1;
        #1 check("R8 before edge", pend_q, 4'b0000);
        step("R1"); step("R1");
        // R1: line in CPU 1 bank, enable in CPU 3 bank -> nothing extra
        line_bank[1*32+7] = 1'b1; en_bank[3*32+7] = 1'b1;
        step("R1 cross bank"); step("R1 cross bank");
        line_bank[2*32+5] = 1'b0;
        step("R1 line low");
        // R2/R3: shared id 40 -> index 8 targets CPU 3
        tgt_shr[8*CW +: CW] = 2'd3; line_shr[8] = 1'b1;
        step("R2 not enabled");
        en_shr[8] = 1'b1;
        step("R2"); step("R2");
        tgt_shr[8*CW +: CW] = 2'd1;
        step("R3 retarget"); step("R3 retarget");
        line_shr[8] = 1'b0; en_shr[8] = 1'b0;
        step("R2 off");
        // R4/R5/R6: level banked id 5 on CPU 2
        line_bank[2*32+5] = 1'b1;
        step("R4 pend");
        deliver(5, 2);
        step("R4 masked");
        step("R4 masked");
        line_bank[2*32+5] = 1'b0;
        step("R6 drop");
        line_bank[2*32+5] = 1'b1;
        step("R6 reraise"); step("R6 reraise");
        finish_eoi(5, 2);
        step("R5 eoi"); step("R5 eoi");
        // R5: completing on another CPU's bank must not unmask CPU 2
        deliver(5, 2);
        step("R4 again");
        finish_eoi(5, 0);
        step("R5 wrong bank"); step("R5 wrong bank");
        finish_eoi(5, 2);
        step("R5 right bank");
        // R4 shared level id 50 -> index 18 on CPU 0
        tgt_shr[18*CW +: CW] = 2'd0; line_shr[18] = 1'b1; en_shr[18] = 1'b1;
        step("R4 shared pend");
        deliver(50, 0);
        step("R4 shared masked");
        line_bank[2*32+5] = 1'b0;
        step("R4 shared masked");
        finish_eoi(50, 0);
        step("R5 shared");
        // R9: edge shared id 41 -> index 9 on CPU 2
        line_shr[18] = 1'b0;
        trig_edge[41] = 1'b1; tgt_shr[9*CW +: CW] = 2'd2; line_shr[9] = 1'b1; en_shr[9] = 1'b1;
        step("R9 pend");
        deliver(41, 2);
        step("R9 edge"); step("R9 edge");
        // R9: edge banked id 3 on CPU 3
        trig_edge[3] = 1'b1; line_bank[3*32+3] = 1'b1; en_bank[3*32+3] = 1'b1;
        step("R9 banked");
        deliver(3, 3);
        step("R9 banked edge"); step("R9 banked edge");
        // R7: disable again with work pending
        dist_en = 1'b0;
        step("R7 off"); step("R7 off");
        dist_en = 1'b1;
        step("R7 on");
        // R10: reset clears in-progress bits
        trig_edge[41] = 1'b0;
        deliver(41, 2);
        step("R4 before reset");
        rst_n = 1'b0;
        step("R10 reset");
        rst_n = 1'b1;
        step("R10 act cleared"); step("R10 act cleared");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: pend_q=%b expected=finish", pend_q);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule